// File: doc/BRIEF.md
# DRAM Read/Write Turnaround Scheduler

This block chooses, cycle by cycle, whether a DRAM controller's command multiplexer serves reads or writes. Between the two directions it places fixed bus turnaround windows. A read-to-write switch takes the PHY read latency. A write-to-read switch takes the write-to-read gap, plus the write latency in controller cycles, plus the CAS-to-CAS gap. A per-mode starvation timer caps how long one direction may keep the bus while the other direction has pending work.

Refresh is handled against the bank machines. A refresh request is broadcast to every bank, and the scheduler waits until all banks have granted. It then produces a one-cycle refresh-issue strobe. The block also spaces CAS commands and row activations by their minimum gaps. The per-bank requesters, the command encoder and the data path sit outside this block. They read the mode and the enables, and they report back each CAS or activate they fire.

Top module: `ddr_turnaround_sched`

## Requirements
- R1: After reset, sched_state_o is READ (code 0), no bank refresh request is raised, and the starvation timer starts expired, so a pending write may leave READ at once even while reads are pending.
- R2: When READ sees write work (and either no read work or an expired timer), sched_state_o shows RTW (code 1) for RD_LAT-1 cycles and then WRITE (code 2). WRITE appears exactly RD_LAT cycles after the deciding READ cycle.
- R3: When WRITE sees read work (and either no write work or an expired timer), sched_state_o shows WTR (code 3) and then READ. READ appears exactly T_WTR + ceil(CWL/NPHASES) + T_CCD cycles after the deciding WRITE cycle.
- R4: With both directions pending, WRITE is held for exactly WR_TIME cycles and is then followed by WTR.
- R5: With both directions pending, READ is held for exactly RD_TIME cycles and is then followed by RTW. The timer reloads on each entry to READ or WRITE, and it counts only in cycles where the opposite direction has work pending.
- R6: A mode whose own side is still busy is kept for as long as the other side has no work.
- R7: A refresh request taken in READ raises every bit of bank_ref_req_o from the next cycle, in state REF_WAIT (code 4). No refresh is issued while any bank grant is low.
- R8: In the cycle after all grants are seen high, the state is REF_PRE (code 5). In the cycle after that, ref_issue_o pulses for one cycle in REF_ISSUE (code 6). After the pulse the scheduler returns to READ and drops bank_ref_req_o.
- R9: A refresh request beats a pending write in the same READ cycle. In WRITE, a refresh request forces WTR.
- R10: cas_rd_en_o is high only in READ and cas_wr_en_o only in WRITE. After a cas_fire_i, both stay low for T_CCD-1 cycles. A T_CCD of 0 or 1 imposes no gap.
- R11: act_en_o is high only in READ or WRITE. After an act_fire_i, it stays low for T_RRD-1 cycles. A T_RRD of 0 or 1 imposes no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_avail_i | input | 1 | Some bank has read work pending |
| wr_avail_i | input | 1 | Some bank has write work pending |
| refresh_req_i | input | 1 | Refresh requested by the refresher |
| ref_gnt_i | input | NBANKS | Per-bank refresh grant |
| cas_fire_i | input | 1 | A CAS command was issued this cycle |
| act_fire_i | input | 1 | An activate was issued this cycle |
| sched_state_o | output | 3 | Scheduler state code |
| cas_rd_en_o | output | 1 | Read CAS permitted |
| cas_wr_en_o | output | 1 | Write CAS permitted |
| act_en_o | output | 1 | Activate permitted |
| bank_ref_req_o | output | NBANKS | Refresh request to each bank machine |
| ref_issue_o | output | 1 | One-cycle refresh command strobe |

## Verification
A refresh request and a direction switch can both be due in the same READ cycle. The bench provokes this by raising refresh_req_i and wr_avail_i at the same clock edge, with reads idle. The collision is judged by the next state: it must be REF_WAIT rather than RTW. The same collision is also driven during WRITE, where the bench expects WTR to follow at once, with no wait for the starvation timer.

// File: rtl/ddrsch_pkg.sv
package ddrsch_pkg;
  typedef enum logic [2:0] {
    ST_READ      = 3'd0,
    ST_RTW       = 3'd1,
    ST_WRITE     = 3'd2,
    ST_WTR       = 3'd3,
    ST_REF_WAIT  = 3'd4,
    ST_REF_PRE   = 3'd5,
    ST_REF_ISSUE = 3'd6
  } sched_st_e;
endpackage

// File: rtl/spacing_gate.sv
module spacing_gate #(
  parameter int GAP = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic ok_o
);
  generate
    if (GAP <= 1) begin : g_open
      assign ok_o = 1'b1;
    end else begin : g_cnt
      localparam int CW = $clog2(GAP);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          cnt_q <= '0;
        else if (fire_i)      cnt_q <= CW'(GAP - 1);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end

      assign ok_o = (cnt_q == '0);

      // R10 R11
      gap_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_i |=> !ok_o);
    end
  endgenerate
endmodule

// File: rtl/starve_timer.sv
module starve_timer #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  // reset value zero: timer starts expired
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R5
  expired_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !load_i) |=> expired_o);
endmodule

// File: rtl/ddr_turnaround_sched.sv
module ddr_turnaround_sched
  import ddrsch_pkg::*;
#(
  parameter int NBANKS  = 8,
  parameter int RD_LAT  = 5,
  parameter int CWL     = 3,
  parameter int NPHASES = 2,
  parameter int T_WTR   = 2,
  parameter int T_CCD   = 1,
  parameter int T_RRD   = 0,
  parameter int RD_TIME = 32,
  parameter int WR_TIME = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_avail_i,
  input  logic              wr_avail_i,
  input  logic              refresh_req_i,
  input  logic [NBANKS-1:0] ref_gnt_i,
  input  logic              cas_fire_i,
  input  logic              act_fire_i,
  output logic [2:0]        sched_state_o,
  output logic              cas_rd_en_o,
  output logic              cas_wr_en_o,
  output logic              act_en_o,
  output logic [NBANKS-1:0] bank_ref_req_o,
  output logic              ref_issue_o
);
  localparam int RTW_CYC  = RD_LAT;
  localparam int WTR_CYC  = T_WTR + (CWL + NPHASES - 1) / NPHASES + T_CCD;
  localparam int TURN_MAX = (RTW_CYC > WTR_CYC) ? RTW_CYC : WTR_CYC;
  localparam int TURN_W   = $clog2(TURN_MAX + 1);
  localparam int TIME_MAX = (RD_TIME > WR_TIME) ? RD_TIME : WR_TIME;
  localparam int TIME_W   = $clog2(TIME_MAX + 1);

  sched_st_e           state_q, state_d;
  logic [TURN_W-1:0]   turn_q, turn_val;
  logic                turn_load;
  logic [TIME_W-1:0]   tmr_val;
  logic                tmr_load, tmr_dec, tmr_exp;
  logic                ccd_ok, rrd_ok, ref_active;

  always_comb begin
    state_d   = state_q;
    turn_load = 1'b0;
    turn_val  = '0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    tmr_dec   = 1'b0;
    unique case (state_q)
      ST_READ: begin
        tmr_dec = wr_avail_i && !tmr_exp;
        if (refresh_req_i) begin
          state_d = ST_REF_WAIT;
        end else if (wr_avail_i && (!rd_avail_i || tmr_exp)) begin
          state_d   = ST_RTW;
          turn_load = 1'b1;
          turn_val  = TURN_W'(RTW_CYC - 2);
        end
      end
      ST_RTW: begin
        if (turn_q == '0) begin
          state_d  = ST_WRITE;
          tmr_load = 1'b1;
          tmr_val  = TIME_W'(WR_TIME - 1);
        end
      end
      ST_WRITE: begin
        tmr_dec = rd_avail_i && !tmr_exp;
        if (refresh_req_i || (rd_avail_i && (!wr_avail_i || tmr_exp))) begin
          state_d   = ST_WTR;
          turn_load = 1'b1;
          turn_val  = TURN_W'(WTR_CYC - 2);
        end
      end
      ST_WTR: begin
        if (turn_q == '0) begin
          state_d  = ST_READ;
          tmr_load = 1'b1;
          tmr_val  = TIME_W'(RD_TIME - 1);
        end
      end
      ST_REF_WAIT:  if (&ref_gnt_i) state_d = ST_REF_PRE;
      ST_REF_PRE:   state_d = ST_REF_ISSUE;
      ST_REF_ISSUE: begin
        state_d  = ST_READ;
        tmr_load = 1'b1;
        tmr_val  = TIME_W'(RD_TIME - 1);
      end
      default:      state_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_READ;
      turn_q  <= '0;
    end else begin
      state_q <= state_d;
      if (turn_load)          turn_q <= turn_val;
      else if (turn_q != '0)  turn_q <= turn_q - 1'b1;
    end
  end

  starve_timer #(.W(TIME_W)) u_starve (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .dec_i      (tmr_dec),
    .expired_o  (tmr_exp)
  );

  spacing_gate #(.GAP(T_CCD)) u_ccd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (cas_fire_i),
    .ok_o   (ccd_ok)
  );

  spacing_gate #(.GAP(T_RRD)) u_rrd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (act_fire_i),
    .ok_o   (rrd_ok)
  );

  assign ref_active     = (state_q == ST_REF_WAIT) || (state_q == ST_REF_PRE) ||
                          (state_q == ST_REF_ISSUE);
  assign sched_state_o  = state_q;
  assign cas_rd_en_o    = (state_q == ST_READ) && ccd_ok;
  assign cas_wr_en_o    = (state_q == ST_WRITE) && ccd_ok;
  assign act_en_o       = ((state_q == ST_READ) || (state_q == ST_WRITE)) && rrd_ok;
  assign bank_ref_req_o = {NBANKS{ref_active}};
  assign ref_issue_o    = (state_q == ST_REF_ISSUE);

  // R7
  ref_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REF_WAIT && !(&ref_gnt_i)) |=> (state_q == ST_REF_WAIT && !ref_issue_o));

  // R8
  ref_issue_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_issue_o |-> $past(&ref_gnt_i, 2));

  // R8
  ref_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bank_ref_req_o[0]) |-> $past(ref_issue_o));

  // R9
  ref_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READ && refresh_req_i) |=> (state_q == ST_REF_WAIT));

  // R2
  rtw_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RTW) |=> (state_q == ST_RTW || state_q == ST_WRITE));
endmodule

// File: tb/ddr_turnaround_sched_bench.sv
`timescale 1ns/1ps
module ddr_turnaround_sched_bench;
  localparam int NB      = 8;
  localparam int RD_LAT  = 5;
  localparam int CWL     = 3;
  localparam int NPH     = 2;
  localparam int T_WTR   = 2;
  localparam int T_CCD   = 3;
  localparam int T_RRD   = 6;
  localparam int RD_TIME = 32;
  localparam int WR_TIME = 16;
  localparam int WTR_EXP = T_WTR + (CWL + NPH - 1) / NPH + T_CCD;

  localparam int S_READ = 0, S_RTW = 1, S_WRITE = 2, S_WTR = 3;
  localparam int S_RWAIT = 4, S_RPRE = 5, S_RISS = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rd_avail, wr_avail, refresh_req, cas_fire, act_fire;
  logic [NB-1:0] ref_gnt;
  logic [2:0] st;
  logic cas_rd_en, cas_wr_en, act_en, ref_issue;
  logic [NB-1:0] bank_ref_req;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ddr_turnaround_sched #(
    .NBANKS(NB), .RD_LAT(RD_LAT), .CWL(CWL), .NPHASES(NPH), .T_WTR(T_WTR),
    .T_CCD(T_CCD), .T_RRD(T_RRD), .RD_TIME(RD_TIME), .WR_TIME(WR_TIME)
  ) u_ddr_turnaround_sched (
    .clk_i(clk), .rst_ni(rst_ni), .rd_avail_i(rd_avail), .wr_avail_i(wr_avail),
    .refresh_req_i(refresh_req), .ref_gnt_i(ref_gnt), .cas_fire_i(cas_fire),
    .act_fire_i(act_fire), .sched_state_o(st), .cas_rd_en_o(cas_rd_en),
    .cas_wr_en_o(cas_wr_en), .act_en_o(act_en), .bank_ref_req_o(bank_ref_req),
    .ref_issue_o(ref_issue)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    rd_avail = 0; wr_avail = 0; refresh_req = 0; cas_fire = 0; act_fire = 0;
    ref_gnt = '0;
    tick(); tick();
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic wait_state(int s);
    for (int i = 0; i < 200 && int'(st) != s; i++) tick();
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 state", st, S_READ);
    check("R1 bank_ref_req", bank_ref_req, 0);
    check("R1 ref_issue", ref_issue, 0);
    check("R10 cas_rd_en in READ", cas_rd_en, 1);
    check("R10 cas_wr_en in READ", cas_wr_en, 0);
    check("R11 act_en in READ", act_en, 1);
  endtask

  task automatic t_rtw_wtr();
    do_reset();
    rd_avail = 1; wr_avail = 1;  // reads pending too: expired timer lets write in
    for (int i = 1; i <= RD_LAT; i++) begin
      tick();
      check("R2 R1 rtw timing", st, (i < RD_LAT) ? S_RTW : S_WRITE);
    end
    check("R10 cas_wr_en in WRITE", cas_wr_en, 1);
    rd_avail = 1; wr_avail = 0;
    for (int i = 1; i <= WTR_EXP; i++) begin
      tick();
      check("R3 wtr timing", st, (i < WTR_EXP) ? S_WTR : S_READ);
    end
  endtask

  task automatic t_starve();
    int n;
    do_reset();
    rd_avail = 1; wr_avail = 1;
    wait_state(S_WRITE);
    n = 0;
    while (int'(st) == S_WRITE && n < 200) begin n++; tick(); end
    check("R4 write hold", n, WR_TIME);
    check("R4 after write", st, S_WTR);
    wait_state(S_READ);
    n = 0;
    while (int'(st) == S_READ && n < 200) begin n++; tick(); end
    check("R5 read hold", n, RD_TIME);
    check("R5 after read", st, S_RTW);
  endtask

  task automatic t_count_only_pending();
    int n;
    do_reset();
    wr_avail = 1;
    wait_state(S_WRITE);
    rd_avail = 1; wr_avail = 0;
    wait_state(S_READ);
    for (int i = 0; i < 50; i++) tick();
    check("R6 read kept while no write", st, S_READ);
    wr_avail = 1;
    n = 0;
    while (int'(st) == S_READ && n < 200) begin n++; tick(); end
    check("R5 timer counts only when pending", n, RD_TIME);
    rd_avail = 0;
    wait_state(S_WRITE);
    for (int i = 0; i < 40; i++) tick();
    check("R6 write kept while no read", st, S_WRITE);
  endtask

  task automatic t_refresh();
    do_reset();
    refresh_req = 1;
    tick();
    check("R7 wait state", st, S_RWAIT);
    check("R7 broadcast", bank_ref_req, (1 << NB) - 1);
    for (int b = 0; b < NB - 1; b++) begin
      ref_gnt[b] = 1'b1;
      tick(); tick();
      check("R7 no issue with missing grant", ref_issue, 0);
      check("R7 still waiting", st, S_RWAIT);
    end
    ref_gnt[NB-1] = 1'b1;
    tick();
    check("R8 pre state", st, S_RPRE);
    check("R8 no issue yet", ref_issue, 0);
    tick();
    check("R8 issue state", st, S_RISS);
    check("R8 issue strobe", ref_issue, 1);
    refresh_req = 0; ref_gnt = '0;
    tick();
    check("R8 back to READ", st, S_READ);
    check("R8 request dropped", bank_ref_req, 0);
    check("R8 strobe one cycle", ref_issue, 0);
  endtask

  task automatic t_collide();
    do_reset();
    refresh_req = 1; wr_avail = 1;
    tick();
    check("R9 refresh beats write in READ", st, S_RWAIT);
    check("R11 act_en off in refresh", act_en, 0);
    ref_gnt = '1;
    tick(); tick();
    refresh_req = 0; ref_gnt = '0;
    wait_state(S_WRITE);
    rd_avail = 0; wr_avail = 1; refresh_req = 1;
    tick();
    check("R9 refresh forces WTR", st, S_WTR);
    check("R10 cas_wr_en off in WTR", cas_wr_en, 0);
    refresh_req = 0;
  endtask

  task automatic t_spacing();
    do_reset();
    cas_fire = 1;
    tick();
    cas_fire = 0;
    for (int i = 1; i < T_CCD; i++) begin
      check("R10 ccd gap", cas_rd_en, 0);
      tick();
    end
    check("R10 ccd reopen", cas_rd_en, 1);
    act_fire = 1;
    tick();
    act_fire = 0;
    for (int i = 1; i < T_RRD; i++) begin
      check("R11 rrd gap", act_en, 0);
      tick();
    end
    check("R11 rrd reopen", act_en, 1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_rtw_wtr();
    t_starve();
    t_count_only_pending();
    t_refresh();
    t_collide();
    t_spacing();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule